// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic stage of a small microcontroller core. Each cycle it can take two register operands, or one register and an 8-bit immediate, together with an operation code. It returns the 8-bit result to the register file through a combinational result bus and a write strobe. The supported operations are add, add with carry-in, subtract, AND, AND with immediate and OR. Every operation finishes in one clock cycle.

An eight-flag status word is rewritten on the clock edge that ends each accepted operation. Five of its flags come from the result: carry, half carry, two's-complement overflow, negative and zero. The sign flag is derived from two of those. The two top bits (interrupt enable and bit-copy storage) belong to other parts of the core. This block never changes them, so they stay at their reset value of zero.

Top module: `alu8_flags`

## Requirements
- R1: While `rst` is high at a clock edge, `sreg` becomes 0x00. With `op_valid` low, `wr_en` is 0.
- R2: The operation codes on `op_sel` are ADD=0, ADC=1, SUB=2, AND=3, ANDI=4 and OR=5. For ADD, ADC and SUB, `result` is opa+opb, opa+opb+C and opa−opb, each taken modulo 256.
- R3: `result` is opa&opb for AND, opa&imm for ANDI and opa|opb for OR. ANDI ignores `opb`, and AND and OR ignore `imm`.
- R4: `wr_en` is 1, in the same cycle, exactly when `op_valid` is 1 and `op_sel` is 0 to 5. Codes 6 and 7 are reserved.
- R5: Status bit 0 (C) becomes the carry out of bit 7 for ADD and ADC. For SUB it becomes the borrow, set when opa < opb unsigned.
- R6: Status bit 5 (H) becomes the carry out of bit 3 for ADD and ADC. For SUB it is set when opa[3:0] < opb[3:0].
- R7: Status bit 3 (V) becomes the signed overflow: for an add, both operands share a sign that the result lacks; for SUB, the operand signs differ and the result sign differs from opa. Bit 2 (N) becomes result bit 7. Bit 4 (S) equals N XOR V.
- R8: Status bit 1 (Z) becomes 1 exactly when the 8-bit result is zero.
- R9: AND, ANDI and OR clear V, update N, Z and S, and leave C and H unchanged.
- R10: Status bits 7 (I) and 6 (T) are never changed by any operation.
- R11: `sreg` changes only on the clock edge that ends an accepted operation (`wr_en` high). With `op_valid` low or a reserved code, it holds.
- R12: ADC takes its carry-in from C as it stood before the edge. Back-to-back operations see each other's flags. Driving the same value on both operand ports (a register added to itself) gives correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 3 | Operation code |
| opa | input | 8 | First register operand |
| opb | input | 8 | Second register operand |
| imm | input | 8 | Immediate operand for ANDI |
| result | output | 8 | Operation result, combinational |
| wr_en | output | 1 | Result write strobe to the register file |
| sreg | output | 8 | Status word: I,T,H,S,V,N,Z,C from bit 7 to bit 0 |

## Verification
Two things meet on one edge: an ADC reads the carry flag, and that same edge rewrites it. Likewise, a logic operation keeps C and H while replacing N, Z and V. The bench first primes C to a known state with a SUB or ADD, issues ADC in the very next cycle, and then mixes logic operations between arithmetic ones. It judges each step against a running status model held in the bench, across operand sweeps and sign and nibble corner values.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
    parameter int unsigned ALU_W  = 8;
    parameter int unsigned NIB_W  = ALU_W / 2;
    parameter int unsigned SREG_W = 8;

    // status bit positions
    localparam int unsigned FL_C = 0;
    localparam int unsigned FL_Z = 1;
    localparam int unsigned FL_N = 2;
    localparam int unsigned FL_V = 3;
    localparam int unsigned FL_S = 4;
    localparam int unsigned FL_H = 5;
    localparam int unsigned FL_T = 6;
    localparam int unsigned FL_I = 7;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_AND  = 3'd3,
        OP_ANDI = 3'd4,
        OP_OR   = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_t;

    typedef struct packed {
        logic legal;
        logic use_imm;
        logic is_sub;
        logic is_adc;
        logic is_logic;
        logic sel_or;
    } ctl_t;

    typedef struct packed {
        logic [ALU_W-1:0] sum;
        logic             cout;
        logic             hcar;
        logic             ovf;
    } arith_t;

    function automatic ctl_t decode_op(op_t op);
        ctl_t c;
        c = '0;
        unique case (op)
            OP_ADD:  c.legal = 1'b1;
            OP_ADC:  begin c.legal = 1'b1; c.is_adc = 1'b1; end
            OP_SUB:  begin c.legal = 1'b1; c.is_sub = 1'b1; end
            OP_AND:  begin c.legal = 1'b1; c.is_logic = 1'b1; end
            OP_ANDI: begin c.legal = 1'b1; c.is_logic = 1'b1; c.use_imm = 1'b1; end
            OP_OR:   begin c.legal = 1'b1; c.is_logic = 1'b1; c.sel_or = 1'b1; end
            default: c = '0;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/alu8_adder.sv
`timescale 1ns/1ps
module alu8_adder
    import alu8_pkg::*;
(
    input  logic [ALU_W-1:0] a,
    input  logic [ALU_W-1:0] b,
    input  logic             cin,
    input  logic             sub,
    output arith_t           res
);
    localparam int unsigned LO_W = NIB_W;

    logic [ALU_W-1:0] bx;
    logic             c0;
    logic [ALU_W:0]   full;
    logic [LO_W:0]    low;

    always_comb begin
        bx   = sub ? ~b : b;
        c0   = sub ? 1'b1 : cin;
        full = {1'b0, a} + {1'b0, bx} + {{ALU_W{1'b0}}, c0};
        low  = {1'b0, a[LO_W-1:0]} + {1'b0, bx[LO_W-1:0]} + {{LO_W{1'b0}}, c0};
        res.sum  = full[ALU_W-1:0];
        // subtract reports borrow, the inverse of the internal carry
        res.cout = sub ? ~full[ALU_W] : full[ALU_W];
        res.hcar = sub ? ~low[LO_W] : low[LO_W];
        res.ovf  = (a[ALU_W-1] == bx[ALU_W-1]) && (full[ALU_W-1] != a[ALU_W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic
    import alu8_pkg::*;
(
    input  logic [ALU_W-1:0] a,
    input  logic [ALU_W-1:0] b,
    input  logic             sel_or,
    output logic [ALU_W-1:0] y
);
    always_comb y = sel_or ? (a | b) : (a & b);
endmodule

// File: rtl/alu8_flagreg.sv
`timescale 1ns/1ps
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic              logic_op,
    input  logic              nxt_c,
    input  logic              nxt_h,
    input  logic              nxt_v,
    input  logic              nxt_n,
    input  logic              nxt_z,
    output logic [SREG_W-1:0] sreg
);
    logic v_eff;
    always_comb v_eff = logic_op ? 1'b0 : nxt_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (upd) begin
            if (!logic_op) begin
                sreg[FL_C] <= nxt_c;
                sreg[FL_H] <= nxt_h;
            end
            sreg[FL_V] <= v_eff;
            sreg[FL_N] <= nxt_n;
            sreg[FL_Z] <= nxt_z;
            sreg[FL_S] <= nxt_n ^ v_eff;
        end
    end

    p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(sreg));
    p_keep_it_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sreg[FL_I] == $past(sreg[FL_I])) && (sreg[FL_T] == $past(sreg[FL_T])));
    p_logic_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (upd && logic_op) |=> (sreg[FL_C] == $past(sreg[FL_C])) &&
                              (sreg[FL_H] == $past(sreg[FL_H])) && !sreg[FL_V]);
    p_sign_r7: assert property (@(posedge clk) disable iff (rst)
        sreg[FL_S] == (sreg[FL_N] ^ sreg[FL_V]));
endmodule

// File: rtl/alu8_flags.sv
`timescale 1ns/1ps
module alu8_flags
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_sel,
    input  logic [ALU_W-1:0]  opa,
    input  logic [ALU_W-1:0]  opb,
    input  logic [ALU_W-1:0]  imm,
    output logic [ALU_W-1:0]  result,
    output logic              wr_en,
    output logic [SREG_W-1:0] sreg
);
    ctl_t             ctl;
    logic [ALU_W-1:0] src_b;
    logic             cin;
    arith_t           ar;
    logic [ALU_W-1:0] lres;

    always_comb begin
        ctl    = decode_op(op_t'(op_sel));
        src_b  = ctl.use_imm ? imm : opb;
        cin    = ctl.is_adc & sreg[FL_C];
        wr_en  = op_valid & ctl.legal;
    end

    alu8_adder u_add (
        .a   (opa),
        .b   (src_b),
        .cin (cin),
        .sub (ctl.is_sub),
        .res (ar)
    );

    alu8_logic u_log (
        .a      (opa),
        .b      (src_b),
        .sel_or (ctl.sel_or),
        .y      (lres)
    );

    always_comb result = ctl.is_logic ? lres : ar.sum;

    alu8_flagreg u_flg (
        .clk      (clk),
        .rst      (rst),
        .upd      (wr_en),
        .logic_op (ctl.is_logic),
        .nxt_c    (ar.cout),
        .nxt_h    (ar.hcar),
        .nxt_v    (ar.ovf),
        .nxt_n    (result[ALU_W-1]),
        .nxt_z    (result == '0),
        .sreg     (sreg)
    );

    p_zero_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (sreg[FL_Z] == ($past(result) == '0)));
    p_neg_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (sreg[FL_N] == $past(result[ALU_W-1])));
endmodule

// File: tb/alu8_flags_test.sv
`timescale 1ns/1ps
module alu8_flags_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] opa = 8'h00, opb = 8'h00, imm = 8'h00;
    logic [7:0] result;
    logic       wr_en;
    logic [7:0] sreg;

    int n_run = 0;
    int n_bad = 0;
    logic [7:0] exp_sr = 8'h00;
    bit done = 0;

    always #10 clk = ~clk;

    alu8_flags uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .opa(opa), .opb(opb), .imm(imm),
        .result(result), .wr_en(wr_en), .sreg(sreg)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (op %0d a %0h b %0h)",
                     tag, act, exp, op_sel, opa, opb);
        end
    endtask

    task automatic run_op(input logic [2:0] code, input logic vld,
                          input logic [7:0] a, input logic [7:0] b, input logic [7:0] im);
        logic [8:0] w;
        logic [7:0] r;
        logic       c, h, v, n, z, legal, lg;
        logic [7:0] nx;
        @(negedge clk);
        op_sel = code; op_valid = vld; opa = a; opb = b; imm = im;
        #2;
        legal = (code <= 3'd5);
        lg    = (code >= 3'd3) && legal;
        c = exp_sr[0]; h = exp_sr[5]; v = 1'b0; r = 8'h00;
        case (code)
            3'd0: begin w = a + b; r = w[7:0]; c = w[8];
                        h = ({1'b0,a[3:0]} + {1'b0,b[3:0]}) > 5'd15;
                        v = (a[7] == b[7]) && (r[7] != a[7]); end
            3'd1: begin w = a + b + {8'd0, exp_sr[0]}; r = w[7:0]; c = w[8];
                        h = ({1'b0,a[3:0]} + {1'b0,b[3:0]} + {4'd0,exp_sr[0]}) > 5'd15;
                        v = (a[7] == b[7]) && (r[7] != a[7]); end
            3'd2: begin r = a - b; c = a < b; h = a[3:0] < b[3:0];
                        v = (a[7] != b[7]) && (r[7] != a[7]); end
            3'd3: r = a & b;
            3'd4: r = a & im;
            3'd5: r = a | b;
            default: r = 8'h00;
        endcase
        n = r[7]; z = (r == 8'h00);
        chk("R4 wr_en", int'(wr_en), int'(vld & legal));
        if (vld && legal) begin
            if (lg) chk("R3 logic result", int'(result), int'(r));
            else if (code == 3'd1) chk("R12 adc result", int'(result), int'(r));
            else chk("R2 arith result", int'(result), int'(r));
            nx = exp_sr;
            nx[0] = c; nx[5] = h; nx[3] = v; nx[2] = n; nx[1] = z; nx[4] = n ^ v;
        end else begin
            nx = exp_sr;
        end
        @(posedge clk); #1;
        if (!(vld && legal)) chk("R11 status hold", int'(sreg), int'(exp_sr));
        else begin
            if (lg) chk("R9 C/H kept, V clear", int'({sreg[5], sreg[3], sreg[0]}),
                         int'({nx[5], nx[3], nx[0]}));
            else begin
                chk("R5 carry", int'(sreg[0]), int'(nx[0]));
                chk("R6 half carry", int'(sreg[5]), int'(nx[5]));
            end
            chk("R7 V/N/S", int'({sreg[4], sreg[3], sreg[2]}), int'({nx[4], nx[3], nx[2]}));
            chk("R8 zero", int'(sreg[1]), int'(nx[1]));
        end
        chk("R10 I/T untouched", int'(sreg[7:6]), 0);
        exp_sr = nx;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] cn [7];
        cn[0] = 8'h00; cn[1] = 8'h01; cn[2] = 8'h0F; cn[3] = 8'h10;
        cn[4] = 8'h7F; cn[5] = 8'h80; cn[6] = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset status", int'(sreg), 0);
        chk("R1 idle wr_en", int'(wr_en), 0);
        @(negedge clk); rst = 1'b0;

        // corner pairs, all operations, with carry primed both ways before ADC
        for (int i = 0; i < 7; i++)
            for (int j = 0; j < 7; j++) begin
                for (int k = 0; k < 6; k++) run_op(3'(k), 1'b1, cn[i], cn[j], ~cn[j]);
                run_op(3'd2, 1'b1, 8'h00, 8'h01, 8'h00);   // C=1
                run_op(3'd1, 1'b1, cn[i], cn[j], 8'h00);   // R12 back-to-back
                run_op(3'd0, 1'b1, 8'h00, 8'h00, 8'h00);   // C=0
                run_op(3'd1, 1'b1, cn[i], cn[j], 8'h00);
            end

        // strided sweep, mixed ordering so logic ops sit between arithmetic ones
        for (int a = 0; a < 256; a += 5)
            for (int b = 0; b < 256; b += 7) begin
                run_op(3'd0, 1'b1, 8'(a), 8'(b), 8'(b ^ 8'h5A));
                run_op(3'd3, 1'b1, 8'(a), 8'(b), 8'(~b));
                run_op(3'd1, 1'b1, 8'(a), 8'(b), 8'h00);
                run_op(3'd2, 1'b1, 8'(a), 8'(b), 8'h00);
                run_op(3'd5, 1'b1, 8'(a), 8'(b), 8'(b + 3));
                run_op(3'd1, 1'b1, 8'(b), 8'(a), 8'h00);
                run_op(3'd4, 1'b1, 8'(a), 8'(~b), 8'(b));
            end

        // same register on both ports
        for (int a = 0; a < 256; a++) begin
            run_op(3'd0, 1'b1, 8'(a), 8'(a), 8'h00);
            run_op(3'd1, 1'b1, 8'(a), 8'(a), 8'h00);
        end

        // idle and reserved codes hold status
        run_op(3'd2, 1'b1, 8'h00, 8'h01, 8'h00);
        run_op(3'd0, 1'b0, 8'hFF, 8'h01, 8'h00);
        run_op(3'd6, 1'b1, 8'h00, 8'h00, 8'h00);
        run_op(3'd7, 1'b1, 8'h80, 8'h80, 8'h00);
        run_op(3'd3, 1'b0, 8'h00, 8'h00, 8'h00);

        // reset mid-run
        @(negedge clk); rst = 1'b1; op_valid = 1'b0;
        @(posedge clk); #1;
        chk("R1 reset clears status", int'(sreg), 0);
        chk("R1 wr_en idle", int'(wr_en), 0);
        exp_sr = 8'h00;
        @(negedge clk); rst = 1'b0;
        run_op(3'd0, 1'b1, 8'h80, 8'h80, 8'h00);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule